// File: doc/BRIEF.md
# External Interrupt Pin Conditioner

This block sits between four asynchronous external interrupt pins and the group interrupt controller. Each pin is synchronised, then shaped according to a programmable sense type: it either follows the pin level (active high or active low), or captures a rising or falling edge in a sticky latch that software clears by writing a one. A per-pin enable and a shared master enable gate the shaped request before it leaves the block.

All configuration lives in a single 32-bit control word that is written whole and read back combinationally. Pin 0 drives the critical-group request, and pins 1 to 3 drive main-group requests 1 to 3. Source priority and any further masking are handled downstream.

Top module: `extirq_cond`

## Requirements
- R1: After a synchronous reset, the control word reads 0x00000000 and every request output is low.
- R2: The writable fields read back as written: the sense codes in bits 23:16, the master enable in bit 12, the pin enables in bits 11:8 and the routing bit in bit 0. Every other bit reads 0, and that includes the clear bits 27:24, so writing 0xFFFFFFFF reads back 0x00FF1F01.
- R3: With sense code 0 (level high), a pin's request equals the pin level two clock edges after the pin changes. Pin n's sense code sits in bits (23-2n):(22-2n).
- R4: With sense code 3 (level low), a pin's request is the inverse of the synchronised pin level.
- R5: With sense code 1 (rising edge), a low-to-high transition sets a latch three clock edges after the pin changes. The latch holds the request high after the pin returns low.
- R6: With sense code 2 (falling edge), only a high-to-low transition sets the latch. A rising transition leaves the request low.
- R7: Writing 1 to bit (27-n) clears pin n's edge latch. A 0 in that bit leaves the latch unchanged.
- R8: If a clear of a pin's latch and a new qualifying edge on that pin land on the same clock edge, the latch ends up set.
- R9: A request is high only when the master enable (bit 12) and the pin's enable (bit 11-n) are both 1. Edge latches keep capturing while a pin is disabled, and a captured edge appears once the pin is enabled.
- R10: Pin 0 drives crit_req. Pin n (n = 1..3) drives main_req[n-1].
- R11: In the level modes the clear bits have no effect, and the request keeps following the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 4 | Asynchronous external interrupt pins, bit n is pin n |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word write data |
| rd_data | output | 32 | Control word read data |
| crit_req | output | 1 | Conditioned request from pin 0 to the critical group |
| main_req | output | 3 | Conditioned requests from pins 1..3, bit n-1 for pin n |

## Verification
A software clear of a pin's edge latch and a fresh qualifying edge on the same pin can hit the same clock edge. The bench lowers pin 0 in falling-edge mode and counts the register stages so that the write strobe carrying bit 27 is active on exactly the third edge after the pin change. The latch must read set after that edge. Because the latch was cleared beforehand, a design in which the clear wins leaves crit_req low and is reported.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

    localparam int NUM_PINS   = 4;
    localparam int CTRL_W     = 32;
    localparam int MASTER_BIT = 12;
    localparam int ROUTE_BIT  = 0;

    typedef enum logic [1:0] {
        SENSE_HIGH = 2'd0,
        SENSE_RISE = 2'd1,
        SENSE_FALL = 2'd2,
        SENSE_LOW  = 2'd3
    } sense_e;

    typedef struct packed {
        sense_e sense;
        logic   en;
    } pin_cfg_t;

    function automatic int sense_lsb(input int n);
        return 22 - 2 * n;
    endfunction

    function automatic int en_bit(input int n);
        return 11 - n;
    endfunction

    function automatic int clr_bit(input int n);
        return 27 - n;
    endfunction

    function automatic logic is_edge_mode(input sense_e s);
        return (s == SENSE_RISE) || (s == SENSE_FALL);
    endfunction

    function automatic logic is_inverted(input sense_e s);
        return (s == SENSE_FALL) || (s == SENSE_LOW);
    endfunction

endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/extirq_regs.sv
module extirq_regs
    import extirq_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [CTRL_W-1:0]             wr_data,
    output pin_cfg_t [NUM_PINS-1:0]       cfg,
    output logic                          master,
    output logic [NUM_PINS-1:0]           clr,
    output logic [CTRL_W-1:0]             rd_data
);
    pin_cfg_t [NUM_PINS-1:0] cfg_q;
    logic                    master_q;
    logic                    route_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            master_q <= 1'b0;
            route_q  <= 1'b0;
        end else if (wr_en) begin
            for (int n = 0; n < NUM_PINS; n++) begin
                cfg_q[n].sense <= sense_e'(wr_data[sense_lsb(n) +: 2]);
                cfg_q[n].en    <= wr_data[en_bit(n)];
            end
            master_q <= wr_data[MASTER_BIT];
            route_q  <= wr_data[ROUTE_BIT];
        end
    end

    always_comb begin
        for (int n = 0; n < NUM_PINS; n++) begin
            clr[n] = wr_en && wr_data[clr_bit(n)];
        end
    end

    always_comb begin
        rd_data = '0;
        for (int n = 0; n < NUM_PINS; n++) begin
            rd_data[sense_lsb(n) +: 2] = cfg_q[n].sense;
            rd_data[en_bit(n)]         = cfg_q[n].en;
        end
        rd_data[MASTER_BIT] = master_q;
        rd_data[ROUTE_BIT]  = route_q;
    end

    assign cfg    = cfg_q;
    assign master = master_q;

    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[31:28], wr_data[15:13], wr_data[7:1]};

    AST_MASTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data[MASTER_BIT] == $past(wr_data[MASTER_BIT]))); // R2

    AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data[27:24] == 4'd0)); // R2
endmodule

// File: rtl/extirq_pin.sv
module extirq_pin
    import extirq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   pin_s,
    input  sense_e sense,
    input  logic   en,
    input  logic   master,
    input  logic   clr,
    output logic   req
);
    logic prev_q;
    logic latch_q;
    logic latch_d;
    logic edge_mode;
    logic inv;
    logic hit;
    logic level_act;

    assign edge_mode = is_edge_mode(sense);
    assign inv       = is_inverted(sense);
    assign level_act = pin_s ^ inv;
    assign hit       = edge_mode && (inv ? (prev_q && !pin_s) : (pin_s && !prev_q));

    always_comb begin
        if (!edge_mode) latch_d = 1'b0;
        else if (hit)   latch_d = 1'b1;
        else if (clr)   latch_d = 1'b0;
        else            latch_d = latch_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            latch_q <= 1'b0;
        end else begin
            prev_q  <= pin_s;
            latch_q <= latch_d;
        end
    end

    assign req = master && en && (edge_mode ? latch_q : level_act);

    AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (rst)
        (edge_mode && latch_q && !clr) |=> latch_q); // R5

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (edge_mode && latch_q && clr && !hit) |=> !latch_q); // R7

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (hit && clr) |=> latch_q); // R8
endmodule

// File: rtl/extirq_cond.sv
module extirq_cond
    import extirq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [3:0]          pin_i,
    input  logic                wr_en,
    input  logic [31:0]         wr_data,
    output logic [31:0]         rd_data,
    output logic                crit_req,
    output logic [2:0]          main_req
);
    pin_cfg_t [NUM_PINS-1:0] cfg;
    logic                    master;
    logic [NUM_PINS-1:0]     clr;
    logic [NUM_PINS-1:0]     pin_s;
    logic [NUM_PINS-1:0]     req;

    extirq_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg     (cfg),
        .master  (master),
        .clr     (clr),
        .rd_data (rd_data)
    );

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        extirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (pin_i[n]),
            .q   (pin_s[n])
        );

        extirq_pin u_pin (
            .clk    (clk),
            .rst    (rst),
            .pin_s  (pin_s[n]),
            .sense  (cfg[n].sense),
            .en     (cfg[n].en),
            .master (master),
            .clr    (clr[n]),
            .req    (req[n])
        );
    end

    assign crit_req = req[0];
    assign main_req = req[NUM_PINS-1:1];

    AST_CRIT_GATED: assert property (@(posedge clk) disable iff (rst)
        crit_req |-> (rd_data[MASTER_BIT] && rd_data[en_bit(0)])); // R9

    AST_MAIN_GATED: assert property (@(posedge clk) disable iff (rst)
        (main_req != 3'd0) |-> rd_data[MASTER_BIT]); // R9
endmodule

// File: tb/sim_extirq_cond.sv
`timescale 1ns/100ps
module sim_extirq_cond;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  pin_i = 4'd0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = 32'd0;
    logic [31:0] rd_data;
    logic        crit_req;
    logic [2:0]  main_req;

    int n_checks = 0;
    int n_fail   = 0;

    int          q_kind[$];
    logic [31:0] q_exp[$];
    string       q_tag[$];
    event        chk_ev;

    always #2.5 clk = ~clk;

    extirq_cond u0 (
        .clk(clk), .rst(rst), .pin_i(pin_i), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .crit_req(crit_req), .main_req(main_req)
    );

    // monitor: pops expected items and compares against the outputs
    task automatic drain();
        while (q_kind.size() > 0) begin
            int          k   = q_kind.pop_front();
            logic [31:0] e   = q_exp.pop_front();
            string       t   = q_tag.pop_front();
            logic [31:0] act;
            case (k)
                0:       act = rd_data;
                1:       act = {31'd0, crit_req};
                default: act = {29'd0, main_req};
            endcase
            n_checks++;
            if (act !== e) begin
                n_fail++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", t, k, act, e);
            end
        end
    endtask

    initial forever begin
        @(chk_ev);
        drain();
    end

    // driver side
    task automatic expect_out(input int kind, input logic [31:0] e, input string tag);
        q_kind.push_back(kind);
        q_exp.push_back(e);
        q_tag.push_back(tag);
        -> chk_ev;
        #0.1;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic set_pins(input logic [3:0] v);
        @(negedge clk);
        #1 pin_i = v;
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        #1 wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        #1 wr_en = 1'b0; wr_data = 32'd0;
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        tick(4);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        expect_out(0, 32'h0000_0000, "R1 rd_data");
        expect_out(1, 32'd0, "R1 crit_req");
        expect_out(2, 32'd0, "R1 main_req");

        // R2 readback mask
        wr(32'hFFFF_FFFF);
        expect_out(0, 32'h00FF_1F01, "R2 all ones");
        wr(32'h0000_0000);
        expect_out(0, 32'h0000_0000, "R2 all zeros");

        // R3/R10 level high, all enabled
        wr(32'h0000_1F00);
        set_pins(4'b0101);
        tick(1);
        expect_out(1, 32'd0, "R3 latency crit");
        tick(1);
        expect_out(1, 32'd1, "R3 R10 crit follows pin0");
        expect_out(2, 32'b010, "R3 R10 main follows pin2");

        // R4 level low
        wr(32'h00FF_1F00);
        expect_out(1, 32'd0, "R4 crit inverted");
        expect_out(2, 32'b101, "R4 main inverted");
        // R11 clear bits in level mode
        wr(32'h0FFF_1F00);
        expect_out(2, 32'b101, "R11 clear ignored in level mode");
        expect_out(0, 32'h00FF_1F00, "R2 clear bits read zero");
        set_pins(4'b0000);
        tick(4);
        expect_out(2, 32'b111, "R4 low pins active");

        // R5 rising edge
        wr(32'h0055_1F00);
        expect_out(2, 32'd0, "R5 no edge yet");
        set_pins(4'b0010);
        tick(2);
        expect_out(2, 32'd0, "R5 latch not yet set");
        tick(1);
        expect_out(2, 32'b001, "R5 rising latched");
        set_pins(4'b0000);
        tick(4);
        expect_out(2, 32'b001, "R5 latch sticky");

        // R7 clear
        wr(32'h0455_1F00);
        expect_out(2, 32'd0, "R7 clear pin1");
        set_pins(4'b1000);
        tick(4);
        set_pins(4'b0000);
        tick(4);
        expect_out(2, 32'b100, "R5 pin3 latched");
        wr(32'h0255_1F00);
        expect_out(2, 32'b100, "R7 other clear leaves pin3");
        wr(32'h0155_1F00);
        expect_out(2, 32'd0, "R7 clear pin3");

        // R6 falling edge
        wr(32'h00AA_1F00);
        set_pins(4'b0001);
        tick(4);
        expect_out(1, 32'd0, "R6 rising ignored");
        set_pins(4'b0000);
        tick(3);
        expect_out(1, 32'd1, "R6 falling latched");
        wr(32'h08AA_1F00);
        expect_out(1, 32'd0, "R7 clear pin0");

        // R8 clear coincides with latch set
        set_pins(4'b0001);
        tick(4);
        set_pins(4'b0000);
        @(negedge clk);
        @(negedge clk);
        #1 wr_en = 1'b1; wr_data = 32'h08AA_1F00;
        @(negedge clk);
        #1 wr_en = 1'b0; wr_data = 32'd0;
        expect_out(1, 32'd1, "R8 set beats clear");

        // R9 gating
        wr(32'h00AA_0F00);
        expect_out(1, 32'd0, "R9 master off");
        set_pins(4'b0010);
        tick(4);
        set_pins(4'b0000);
        tick(4);
        expect_out(2, 32'd0, "R9 master off main");
        wr(32'h00AA_1700);
        expect_out(1, 32'd0, "R9 pin0 enable off");
        expect_out(2, 32'b001, "R9 latched while disabled");
        wr(32'h00AA_1F00);
        expect_out(1, 32'd1, "R9 pin0 re-enabled");

        #1;
        drain();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule